// File: doc/BRIEF.md
# Packed RGB Pixel Unpacker

This block sits between a 16-bit host write stream and a pixel pipeline that works on 8 bits per colour channel. Each 16-bit word arrives under a valid/ready handshake. A 4-bit format code selects how the words are regrouped and widened into 24-bit pixels. Three layouts are decoded. The first is 5:6:5 colour, one pixel per word. The second is a dense 24-bit layout, two pixels in three words. The third is a padded 24-bit layout, one pixel in two words. In both 24-bit layouts the colour bytes arrive in a fixed scrambled order, so the block keeps the earlier words of a group and puts the channels back together when the last byte needed arrives.

A one-cycle window-start pulse returns the grouping to the first word of a group, so a stream that stopped part way through a group cannot shift the next one. Finished pixels go into a single output register. That register is held while the consumer is not ready, and during that time no further words are taken.

Top module: `pix_unpack`

## Requirements
- R1: After reset `outValid` is 0 and `inReady` is 1.
- R2: With format code 1, each accepted word gives one pixel: red = word[15:11]·8, green = word[10:5]·4, blue = word[4:0]·8, with the low bits zero. `outPixel[23:16]` is red, `[15:8]` is green and `[7:0]` is blue.
- R3: With format code 2 or 3, words are split low byte first. The six bytes of a three-word group carry green 0, red 0, red 1, blue 0, blue 1, green 1, in that order. Pixel 0 is emitted when the second word is accepted and pixel 1 when the third word is accepted.
- R4: With format code 6 or 7, the bytes of a two-word group, low byte first, carry red, an ignored byte, blue, green. One pixel is emitted when the second word is accepted, and the value of the ignored byte has no effect on it.
- R5: With any other format code, words are accepted and no pixel is ever emitted.
- R6: A `winStart` pulse makes the next accepted word the first word of a group. A word accepted in the same cycle as the pulse is treated as that first word.
- R7: While `outValid` is 1 and `outReady` is 0, `inReady` is 0 and `outPixel` holds its value.
- R8: A pixel appears on `outValid`/`outPixel` in the cycle after its completing word is accepted. With `outReady` held high, one word is taken every cycle, and a pixel not replaced by a new one drops `outValid` after one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fmtCode | input | 4 | Input format code, held steady within a window |
| winStart | input | 1 | Start-of-window pulse, restarts word grouping |
| inValid | input | 1 | Input word valid |
| inWord | input | 16 | Input word |
| inReady | output | 1 | Word accepted when high together with inValid |
| outValid | output | 1 | Pixel valid |
| outReady | input | 1 | Consumer takes the pixel when high |
| outPixel | output | 24 | Pixel, red in [23:16], green [15:8], blue [7:0] |

## Verification
The 5:6:5 path is swept across a dense stride of all word values, so a swapped or mis-shifted field shows up as a wrong channel. The two 24-bit layouts are fed long runs of pseudo-random pixels under both of their codes. A lane swap, a reversed byte order or a pixel emitted at the wrong word then gives wrong colours or a valid at the wrong step. A window restart is applied both mid-group and together with a word; a design that kept the stale phase would emit a pixel one word early. Stalling the consumer checks that the held pixel is not overwritten and that no word is lost when the stall is released.

// File: rtl/pixUnpackPkg.sv
package pixUnpackPkg;
  localparam int WORD_W = 16;
  localparam int CH_W   = 8;
  localparam int PIX_W  = 3 * CH_W;
  localparam int FMT_W  = 4;
  localparam int PH_W   = 2;

  typedef enum logic [1:0] {K_NONE, K_565, K_PACK, K_PAD} kind_t;

  // Strobes from sequencing control to the datapath
  typedef struct packed {
    logic keepA;    // store word in slot A
    logic keepB;    // store word in slot B
    logic emit565;
    logic emitP0;   // dense layout, first pixel
    logic emitP1;   // dense layout, second pixel
    logic emitPad;
  } strobe_t;

  function automatic kind_t decodeFmt(logic [FMT_W-1:0] code);
    case (code)
      4'd1:       return K_565;
      4'd2, 4'd3: return K_PACK;
      4'd6, 4'd7: return K_PAD;
      default:    return K_NONE;
    endcase
  endfunction
endpackage

// File: rtl/pixUnpackCtrl.sv
module pixUnpackCtrl
  import pixUnpackPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [FMT_W-1:0] fmtCode,
  input  logic             winStart,
  input  logic             wordTake,
  output strobe_t          strb
);
  logic [PH_W-1:0] phase, effPhase, nextPhase;
  kind_t kind;

  always_comb begin
    kind      = decodeFmt(fmtCode);
    effPhase  = winStart ? '0 : phase;
    nextPhase = effPhase;
    strb      = '0;
    if (wordTake) begin
      case (kind)
        K_565: begin
          strb.emit565 = 1'b1;
          nextPhase    = '0;
        end
        K_PACK: begin
          if (effPhase == 2'd0) begin
            strb.keepA = 1'b1;
            nextPhase  = 2'd1;
          end else if (effPhase == 2'd1) begin
            strb.emitP0 = 1'b1;
            strb.keepB  = 1'b1;
            nextPhase   = 2'd2;
          end else begin
            strb.emitP1 = 1'b1;
            nextPhase   = '0;
          end
        end
        K_PAD: begin
          if (effPhase == 2'd0) begin
            strb.keepA = 1'b1;
            nextPhase  = 2'd1;
          end else begin
            strb.emitPad = 1'b1;
            nextPhase    = '0;
          end
        end
        default: nextPhase = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= '0;
    else       phase <= nextPhase;
  end

  // R3 R4 at most one pixel source per accepted word
  emit_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.emit565, strb.emitP0, strb.emitP1, strb.emitPad}));

  // R6
  win_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winStart && !wordTake) |=> (phase == '0));
endmodule

// File: rtl/pixUnpackData.sv
module pixUnpackData
  import pixUnpackPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [WORD_W-1:0] inWord,
  input  logic              outReady,
  output logic              outValid,
  output logic [PIX_W-1:0]  outPixel
);
  logic [WORD_W-1:0] slotA, slotB;
  logic [CH_W-1:0]   redN, grnN, bluN;
  logic              emitAny;

  always_comb begin
    emitAny = strb.emit565 | strb.emitP0 | strb.emitP1 | strb.emitPad;
    redN = '0; grnN = '0; bluN = '0;
    if (strb.emit565) begin
      redN = {inWord[15:11], 3'b000};
      grnN = {inWord[10:5],  2'b00};
      bluN = {inWord[4:0],   3'b000};
    end else if (strb.emitP0) begin
      redN = slotA[2*CH_W-1:CH_W];
      grnN = slotA[CH_W-1:0];
      bluN = inWord[2*CH_W-1:CH_W];
    end else if (strb.emitP1) begin
      redN = slotB[CH_W-1:0];
      grnN = inWord[2*CH_W-1:CH_W];
      bluN = inWord[CH_W-1:0];
    end else if (strb.emitPad) begin
      redN = slotA[CH_W-1:0];
      grnN = inWord[2*CH_W-1:CH_W];
      bluN = inWord[CH_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotA    <= '0;
      slotB    <= '0;
      outValid <= 1'b0;
      outPixel <= '0;
    end else begin
      if (strb.keepA) slotA <= inWord;
      if (strb.keepB) slotB <= inWord;
      if (emitAny) begin
        outValid <= 1'b1;
        outPixel <= {redN, grnN, bluN};
      end else if (outReady) begin
        outValid <= 1'b0;
      end
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outPixel)));
endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
  import pixUnpackPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [FMT_W-1:0]  fmtCode,
  input  logic              winStart,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inWord,
  output logic              inReady,
  output logic              outValid,
  input  logic              outReady,
  output logic [PIX_W-1:0]  outPixel
);
  strobe_t strb;
  logic    wordTake;

  assign inReady  = !outValid || outReady;
  assign wordTake = inValid && inReady;

  pixUnpackCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .fmtCode(fmtCode), .winStart(winStart),
    .wordTake(wordTake), .strb(strb)
  );

  pixUnpackData i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .inWord(inWord),
    .outReady(outReady), .outValid(outValid), .outPixel(outPixel)
  );

  // R2 R8
  word565_emit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordTake && fmtCode == 4'd1) |=> outValid);

  // R5
  unsupported_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordTake && decodeFmt(fmtCode) == K_NONE) |=> !outValid);
endmodule

// File: tb/test_pix_unpack.sv
module test_pix_unpack;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  fmtCode = 4'd1;
  logic        winStart = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] inWord = '0;
  logic        inReady, outValid;
  logic        outReady = 1'b1;
  logic [23:0] outPixel;

  int checks = 0;
  int fails = 0;
  logic [31:0] seed = 32'h1234_5678;
  bit done = 0;

  always #4 clk = ~clk;

  pix_unpack i_pix_unpack (
    .clk(clk), .rstN(rstN), .fmtCode(fmtCode), .winStart(winStart),
    .inValid(inValid), .inWord(inWord), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .outPixel(outPixel)
  );

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp565(input logic [15:0] w);
    int r, g, b;
    r = (w / 2048) * 8;
    g = ((w / 32) % 64) * 4;
    b = (w % 32) * 8;
    return {r[7:0], g[7:0], b[7:0]};
  endfunction

  function automatic logic [7:0] nextByte();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[23:16];
  endfunction

  task automatic sendWord(input logic [15:0] w, input logic ws);
    @(negedge clk);
    inWord = w; inValid = 1'b1; winStart = ws;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    #1 inValid = 1'b0; winStart = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulseWin();
    @(negedge clk);
    winStart = 1'b1;
    @(posedge clk);
    #1 winStart = 1'b0;
  endtask

  task automatic packGroup(input logic ws);
    logic [7:0] r0, g0, b0, r1, g1, b1;
    r0 = nextByte(); g0 = nextByte(); b0 = nextByte();
    r1 = nextByte(); g1 = nextByte(); b1 = nextByte();
    sendWord({r0, g0}, ws);
    check("R3 no pixel after first word", {23'd0, outValid}, 24'd0);
    sendWord({b0, r1}, 1'b0);
    check("R3 pixel0 valid", {23'd0, outValid}, 24'd1);
    check("R3 pixel0 value", outPixel, {r0, g0, b0});
    sendWord({g1, b1}, 1'b0);
    check("R3 pixel1 valid", {23'd0, outValid}, 24'd1);
    check("R3 pixel1 value", outPixel, {r1, g1, b1});
  endtask

  task automatic padGroup(input logic ws);
    logic [7:0] r, g, b, junk;
    r = nextByte(); g = nextByte(); b = nextByte(); junk = nextByte();
    sendWord({junk, r}, ws);
    check("R4 no pixel after first word", {23'd0, outValid}, 24'd0);
    sendWord({g, b}, 1'b0);
    check("R4 pixel valid", {23'd0, outValid}, 24'd1);
    check("R4 pixel value", outPixel, {r, g, b});
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 outValid after reset", {23'd0, outValid}, 24'd0);
    check("R1 inReady after reset", {23'd0, inReady}, 24'd1);
    rstN = 1'b1;

    // R2 sweep over 5:6:5 words
    fmtCode = 4'd1;
    for (int i = 0; i < 65536; i += 7) begin
      sendWord(i[15:0], 1'b0);
      check("R2 valid", {23'd0, outValid}, 24'd1);
      check("R2 value", outPixel, exp565(i[15:0]));
    end
    sendWord(16'hFFFF, 1'b0);
    check("R2 all ones", outPixel, 24'hF8FCF8);

    // R3 dense layout, both codes
    fmtCode = 4'd2;
    for (int i = 0; i < 300; i++) packGroup(1'b0);
    fmtCode = 4'd3;
    for (int i = 0; i < 300; i++) packGroup(1'b0);

    // R4 padded layout, both codes
    fmtCode = 4'd6;
    for (int i = 0; i < 300; i++) padGroup(1'b0);
    fmtCode = 4'd7;
    for (int i = 0; i < 300; i++) padGroup(1'b0);

    // R5 unsupported codes
    for (int c = 0; c < 16; c++) begin
      if (c == 1 || c == 2 || c == 3 || c == 6 || c == 7) continue;
      fmtCode = c[3:0];
      for (int k = 0; k < 3; k++) begin
        sendWord({nextByte(), nextByte()}, 1'b0);
        check("R5 no output", {23'd0, outValid}, 24'd0);
        check("R5 word taken", {23'd0, inReady}, 24'd1);
      end
    end

    // R6 restart mid-group, alone and with a word
    fmtCode = 4'd2;
    sendWord(16'hDEAD, 1'b0);
    pulseWin();
    packGroup(1'b0);
    sendWord(16'hBEEF, 1'b0);
    sendWord(16'hCAFE, 1'b0);
    packGroup(1'b1);
    fmtCode = 4'd6;
    sendWord(16'h5A5A, 1'b0);
    pulseWin();
    padGroup(1'b0);
    sendWord(16'hA5A5, 1'b0);
    padGroup(1'b1);

    // R7 back-pressure
    fmtCode = 4'd1;
    @(negedge clk);
    outReady = 1'b0;
    sendWord(16'h1234, 1'b0);
    check("R7 stalled pixel valid", {23'd0, outValid}, 24'd1);
    check("R7 inReady low", {23'd0, inReady}, 24'd0);
    inWord = 16'hABCD; inValid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R7 inReady held low", {23'd0, inReady}, 24'd0);
      check("R7 pixel held", outPixel, exp565(16'h1234));
    end
    outReady = 1'b1;
    #1 check("R7 inReady on release", {23'd0, inReady}, 24'd1);
    @(posedge clk);
    #1 inValid = 1'b0;
    @(negedge clk);
    check("R7 next pixel valid", {23'd0, outValid}, 24'd1);
    check("R7 next pixel value", outPixel, exp565(16'hABCD));
    @(negedge clk);
    check("R8 valid drops", {23'd0, outValid}, 24'd0);

    // R8 back-to-back words
    inValid = 1'b1; inWord = 16'h0F0F;
    @(negedge clk);
    check("R8 stream 0", outPixel, exp565(16'h0F0F));
    inWord = 16'hF0F0;
    @(negedge clk);
    check("R8 stream 1", outPixel, exp565(16'hF0F0));
    inWord = 16'h8421;
    @(negedge clk);
    check("R8 stream 2", outPixel, exp565(16'h8421));
    check("R8 stream valid", {23'd0, outValid}, 24'd1);
    inValid = 1'b0;
    @(negedge clk);
    check("R8 idle", {23'd0, outValid}, 24'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule